// File: doc/BRIEF.md
# Sample-Number Stream Aligner

Two sample streams that share a locked clock reach the block over separate ready/valid inputs. Each handshake on a stream delivers one sample group: a 32-bit sample number, carried as two 16-bit halves, and one or two complex 16-bit data channels. Before the two sources are synchronised, their sample numbers can disagree. The block compares the two numbers of the groups at the heads of the streams. It throws away whole groups from whichever stream is behind until both heads carry the same number. From then on it hands out matched group pairs on a single ready/valid output.

The output carries the shared sample number first, then the data channels of stream A, then those of stream B. Two status outputs report the lock state. One shows that the streams are currently aligned. The other is a sticky flag that records that alignment was lost at least once since reset. An interval parameter is accepted so the block can be configured the same way as its neighbours, but it has no effect on behaviour.

Top module: `stream_aligner`

## Requirements
- R1: The sample number of a group is the 32-bit value whose upper 16 bits are the `*_cnt_hi` input and whose lower 16 bits are the `*_cnt_lo` input.
- R2: When both inputs are valid and stream A's number is behind B's, the A group is consumed and discarded. The outputs are `a_ready`=1, `b_ready`=0, `o_valid`=0. "Behind" means that (A − B) mod 2^32, read as a signed 32-bit value, is negative.
- R3: The mirror case: when both inputs are valid and B is behind A, then `b_ready`=1, `a_ready`=0, `o_valid`=0.
- R4: When both inputs are valid and the numbers are equal, `o_valid`=1, and both `a_ready` and `b_ready` equal `o_ready`.
- R5: A delivered pair carries the matched number on `o_cnt_hi`/`o_cnt_lo`, A's data unchanged on `o_a_data` and B's data unchanged on `o_b_data`. Pairs leave in input order and no pair is skipped or repeated.
- R6: The comparison wraps. A number just past 0xFFFFFFFF (for example 0x00000001) counts as ahead of 0xFFFFFFFC, so the 0xFFFFFFFC side is the one discarded.
- R7: When either input is not valid, `o_valid`, `a_ready` and `b_ready` are all 0.
- R8: `o_aligned` is 0 after reset and is 1 in the cycle after the first matched pair is transferred.
- R9: When a discard happens while aligned, `o_aligned` goes to 0 and `o_resync` goes to 1 in the next cycle. `o_resync` then stays 1 until reset, even after alignment is regained.
- R10: While reset is asserted, and in the first cycle after it, `o_aligned` and `o_resync` are 0.
- R11: A group is taken or left as a whole. While a matched pair is offered and `o_ready` is 0, neither input is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Stream A group present |
| a_ready | output | 1 | Stream A group consumed |
| a_cnt_hi | input | 16 | Stream A sample number, upper half |
| a_cnt_lo | input | 16 | Stream A sample number, lower half |
| a_data | input | DCH*32 | Stream A data channels, {I,Q} per channel |
| b_valid | input | 1 | Stream B group present |
| b_ready | output | 1 | Stream B group consumed |
| b_cnt_hi | input | 16 | Stream B sample number, upper half |
| b_cnt_lo | input | 16 | Stream B sample number, lower half |
| b_data | input | DCH*32 | Stream B data channels |
| o_valid | output | 1 | Matched pair available |
| o_ready | input | 1 | Downstream accepts pair |
| o_cnt_hi | output | 16 | Matched sample number, upper half |
| o_cnt_lo | output | 16 | Matched sample number, lower half |
| o_a_data | output | DCH*32 | Stream A data of the pair |
| o_b_data | output | DCH*32 | Stream B data of the pair |
| o_aligned | output | 1 | Streams currently aligned |
| o_resync | output | 1 | Sticky: alignment was lost since reset |

## Verification
A wrong comparison, such as a sign error or an unsigned compare across the wrap, shows up in the same cycle. The wrong stream's ready rises and the other stream never catches up, so the expected pair is missing from the output sequence. A fault in the lock tracker shows one cycle after the triggering transfer or discard, as a wrong `o_aligned` or a `o_resync` that does not rise or later drops. A handshake fault that loses or duplicates a group appears as a shifted sample number in the next delivered pair.

// File: rtl/aln_pkg.sv
package aln_pkg;

  typedef enum logic [1:0] {
    ORD_EQUAL  = 2'd0,
    ORD_A_LAGS = 2'd1,
    ORD_B_LAGS = 2'd2
  } order_t;

  // Assemble the sample number from its two carried halves
  function automatic logic [31:0] join_count(input logic [15:0] hi, input logic [15:0] lo);
    return {hi, lo};
  endfunction

  // Modular comparison: sign of the 32-bit difference picks the laggard
  function automatic order_t order_counts(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] diff;
    diff = a - b;
    if (diff == 32'd0)  return ORD_EQUAL;
    else if (diff[31])  return ORD_A_LAGS;
    else                return ORD_B_LAGS;
  endfunction

endpackage

// File: rtl/aln_unpack.sv
module aln_unpack #(
  parameter int DCH = 2,
  localparam int DW = DCH * 32
) (
  input  logic [15:0]   cnt_hi,
  input  logic [15:0]   cnt_lo,
  input  logic [DW-1:0] data_in,
  output logic [31:0]   count,
  output logic [DW-1:0] data_out
);
  import aln_pkg::*;

  assign count = join_count(cnt_hi, cnt_lo);

  // data channels pass per channel, untouched
  for (genvar c = 0; c < DCH; c++) begin : g_chan
    assign data_out[c*32 +: 32] = data_in[c*32 +: 32];
  end

endmodule

// File: rtl/aln_arbiter.sv
module aln_arbiter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        a_valid,
  input  logic        b_valid,
  input  logic [31:0] a_count,
  input  logic [31:0] b_count,
  input  logic        o_ready,
  output logic        a_ready,
  output logic        b_ready,
  output logic        o_valid,
  output logic        ev_pair_xfer,
  output logic        ev_discard
);
  import aln_pkg::*;

  order_t ord;
  logic   both;

  assign both = a_valid && b_valid;
  assign ord  = order_counts(a_count, b_count);

  always_comb begin
    a_ready = 1'b0;
    b_ready = 1'b0;
    o_valid = 1'b0;
    if (both) begin
      unique case (ord)
        ORD_EQUAL: begin
          o_valid = 1'b1;
          a_ready = o_ready;
          b_ready = o_ready;
        end
        ORD_A_LAGS: a_ready = 1'b1;
        ORD_B_LAGS: b_ready = 1'b1;
        default: ;
      endcase
    end
  end

  assign ev_pair_xfer = o_valid && o_ready;
  assign ev_discard   = (a_ready || b_ready) && !o_valid;

  AST_NO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |-> (!a_ready && !b_ready)); // R11
  AST_IDLE_WHEN_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_valid || !b_valid) |-> (!o_valid && !a_ready && !b_ready)); // R7
  AST_ONE_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_discard |-> $onehot0({a_ready, b_ready})); // R2

endmodule

// File: rtl/aln_track.sv
module aln_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_pair_xfer,
  input  logic ev_discard,
  output logic aligned,
  output logic resync
);

  logic lose_lock;
  assign lose_lock = ev_discard && aligned;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aligned <= 1'b0;
      resync  <= 1'b0;
    end else begin
      if (ev_pair_xfer)    aligned <= 1'b1;
      else if (lose_lock)  aligned <= 1'b0;
      if (lose_lock)       resync  <= 1'b1;
    end
  end

  AST_LOCK_ON_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pair_xfer |=> aligned); // R8
  AST_RESYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> resync); // R9
  AST_LOSE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_discard && aligned) |=> (!aligned && resync)); // R9

endmodule

// File: rtl/stream_aligner.sv
module stream_aligner #(
  parameter int DCH            = 2,
  parameter int ALIGN_INTERVAL = 0,
  localparam int DW = DCH * 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_valid,
  output logic          a_ready,
  input  logic [15:0]   a_cnt_hi,
  input  logic [15:0]   a_cnt_lo,
  input  logic [DW-1:0] a_data,
  input  logic          b_valid,
  output logic          b_ready,
  input  logic [15:0]   b_cnt_hi,
  input  logic [15:0]   b_cnt_lo,
  input  logic [DW-1:0] b_data,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [15:0]   o_cnt_hi,
  output logic [15:0]   o_cnt_lo,
  output logic [DW-1:0] o_a_data,
  output logic [DW-1:0] o_b_data,
  output logic          o_aligned,
  output logic          o_resync
);

  // The interval is accepted for configuration compatibility only.
  if (ALIGN_INTERVAL < 0) begin : g_interval_unused
  end

  logic [31:0] a_count, b_count;
  logic        ev_pair_xfer, ev_discard;

  aln_unpack #(.DCH(DCH)) u_unpack_a (
    .cnt_hi(a_cnt_hi), .cnt_lo(a_cnt_lo), .data_in(a_data),
    .count(a_count), .data_out(o_a_data)
  );

  aln_unpack #(.DCH(DCH)) u_unpack_b (
    .cnt_hi(b_cnt_hi), .cnt_lo(b_cnt_lo), .data_in(b_data),
    .count(b_count), .data_out(o_b_data)
  );

  aln_arbiter u_arb (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .b_valid(b_valid),
    .a_count(a_count), .b_count(b_count),
    .o_ready(o_ready),
    .a_ready(a_ready), .b_ready(b_ready), .o_valid(o_valid),
    .ev_pair_xfer(ev_pair_xfer), .ev_discard(ev_discard)
  );

  aln_track u_track (
    .clk(clk), .rst_n(rst_n),
    .ev_pair_xfer(ev_pair_xfer), .ev_discard(ev_discard),
    .aligned(o_aligned), .resync(o_resync)
  );

  assign o_cnt_hi = a_count[31:16];
  assign o_cnt_lo = a_count[15:0];

  AST_PAIR_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (a_count == b_count)); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (!o_aligned && !o_resync)); // R10

endmodule

// File: tb/tb_stream_aligner.sv
module tb_stream_aligner;
  localparam int DCH = 2;
  localparam int DW  = DCH * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_valid = 1'b0, b_valid = 1'b0, o_ready = 1'b0;
  logic [15:0] a_cnt_hi = '0, a_cnt_lo = '0, b_cnt_hi = '0, b_cnt_lo = '0;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic a_ready, b_ready, o_valid, o_aligned, o_resync;
  logic [15:0] o_cnt_hi, o_cnt_lo;
  logic [DW-1:0] o_a_data, o_b_data;

  always #5 clk = ~clk;

  stream_aligner #(.DCH(DCH), .ALIGN_INTERVAL(16)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_cnt_hi(a_cnt_hi), .a_cnt_lo(a_cnt_lo), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_cnt_hi(b_cnt_hi), .b_cnt_lo(b_cnt_lo), .b_data(b_data),
    .o_valid(o_valid), .o_ready(o_ready), .o_cnt_hi(o_cnt_hi), .o_cnt_lo(o_cnt_lo),
    .o_a_data(o_a_data), .o_b_data(o_b_data), .o_aligned(o_aligned), .o_resync(o_resync)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] qa[$];
  logic [31:0] qb[$];
  logic [31:0] exp_q[$];
  bit m_al, m_res;
  int phase = 0;

  function automatic logic [DW-1:0] data_of(input bit side, input logic [31:0] c);
    logic [DW-1:0] d;
    for (int k = 0; k < DCH; k++)
      d[k*32 +: 32] = {c[15:0] + 16'(k * 7 + 1), c[31:16] ^ (side ? 16'h5A3C : 16'h0F0F)};
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: loads both source queues and predicts the pairs by walking them
  task automatic load(input logic [31:0] a0, input int na, input logic [31:0] b0,
                      input int nb, input int b_skip);
    int i, j;
    qa.delete(); qb.delete(); exp_q.delete();
    for (int k = 0; k < na; k++) qa.push_back(a0 + 32'(k));
    for (int k = 0; k < nb; k++)
      qb.push_back(b0 + 32'(k) + ((b_skip >= 0 && k >= b_skip) ? 32'd1 : 32'd0));
    i = 0; j = 0;
    while (i < qa.size() && j < qb.size()) begin
      longint d = longint'($signed(qa[i] - qb[j]));
      if (d == 0) begin exp_q.push_back(qa[i]); i++; j++; end
      else if (d < 0) i++;
      else j++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; a_valid = 1'b0; b_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!o_aligned && !o_resync, "R10", "status in reset", {o_aligned, o_resync}, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!o_aligned && !o_resync, "R10", "status after reset", {o_aligned, o_resync}, 0);
    m_al = 0; m_res = 0;
  endtask

  // Monitor/step loop: drives heads, checks handshake and pops the scoreboard
  task automatic run(input string name);
    while (qa.size() > 0 && qb.size() > 0) begin
      logic [31:0] ca, cb, e;
      longint d;
      bit mt, er;
      ca = qa[0]; cb = qb[0];
      a_valid = 1; b_valid = 1;
      {a_cnt_hi, a_cnt_lo} = ca; a_data = data_of(0, ca);
      {b_cnt_hi, b_cnt_lo} = cb; b_data = data_of(1, cb);
      phase++;
      o_ready = (phase % 3) != 2;
      @(negedge clk);
      d  = longint'($signed(ca - cb));
      mt = (d == 0);
      er = o_ready;
      chk(o_aligned == m_al, "R8", {name, " aligned"}, o_aligned, m_al);
      chk(o_resync == m_res, "R9", {name, " resync"}, o_resync, m_res);
      if (mt) begin
        chk(o_valid && a_ready == er && b_ready == er, "R4", {name, " match hs"},
            {o_valid, a_ready, b_ready}, {1'b1, er, er});
        if (!er) chk(!a_ready && !b_ready, "R11", {name, " hold"}, {a_ready, b_ready}, 0);
        if (er) begin
          e = exp_q.size() > 0 ? exp_q.pop_front() : 32'hDEAD_BEEF;
          chk({o_cnt_hi, o_cnt_lo} == e, "R1", {name, " number"}, {o_cnt_hi, o_cnt_lo}, e);
          chk(o_a_data == data_of(0, e) && o_b_data == data_of(1, e), "R5", {name, " data"},
              o_a_data ^ o_b_data, data_of(0, e) ^ data_of(1, e));
        end
      end else if (d < 0) begin
        chk(a_ready && !b_ready && !o_valid, (ca > cb) ? "R6" : "R2", {name, " drop A"},
            {o_valid, a_ready, b_ready}, 3'b010);
      end else begin
        chk(b_ready && !a_ready && !o_valid, (cb > ca) ? "R6" : "R3", {name, " drop B"},
            {o_valid, a_ready, b_ready}, 3'b001);
      end
      @(posedge clk);
      if (mt) begin
        if (er) begin m_al = 1; void'(qa.pop_front()); void'(qb.pop_front()); end
      end else begin
        if (m_al) begin m_al = 0; m_res = 1; end
        if (d < 0) void'(qa.pop_front()); else void'(qb.pop_front());
      end
      #1;
    end
    chk(exp_q.size() == 0, "R5", {name, " pairs left"}, exp_q.size(), 0);
    // one side empty: nothing may move
    a_valid = (qa.size() > 0); b_valid = (qb.size() > 0); o_ready = 1;
    @(negedge clk);
    chk(!o_valid && !a_ready && !b_ready, "R7", {name, " one side idle"},
        {o_valid, a_ready, b_ready}, 0);
    @(posedge clk); #1;
    a_valid = 0; b_valid = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    load(32'd100, 10, 32'd103, 6, -1);
    run("A lags");
    do_reset();
    load(32'h0001_FFF0, 5, 32'h0001_FFE0, 25, -1);
    run("B lags");
    do_reset();
    load(32'hFFFF_FFFC, 12, 32'h0000_0001, 6, -1);
    run("wrap");
    do_reset();
    load(32'd200, 16, 32'd200, 12, 6);
    run("resync");
    @(negedge clk);
    chk(o_resync && o_aligned, "R9", "sticky after relock", {o_aligned, o_resync}, 2'b11);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule